// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Event Timer

This block is a down-counting event timer. It counts on a one-cycle enable strobe (`tick`), which may come from a microsecond divider or straight from the oscillator. Software arms it by writing one control word. That word holds a run bit, a repeat-mode bit and a 29-bit load value. The load value is given in minus-one form, so a value of N fires after N+1 ticks.

When the count runs out the timer sets a pending flag, and the flag drives a level-high interrupt line. The flag stays set until software writes a one to the clear bit of a second register at the status offset.

In repeat mode the counter reloads the stored value and keeps running. In single-shot mode it stops and drops its own run bit. Reading the status offset returns the live count and the pending flag.

Top module: `etm_event_timer`

## Requirements
- R1: After reset the run bit, repeat bit, stored load, count and pending flag are all zero, `irq` is low, and both readable offsets return 0.
- R2: A write to byte offset 0x0 stores the control word. Bit 31 is run, bit 30 is repeat and bits [28:0] are the load value. Reading offset 0x0 returns the stored word with all other bits zero.
- R3: With the run bit set and load value N, the count falls by one on each `tick` and the expiry happens on tick N+1, with N=0 firing on the first tick. Cycles without `tick` leave the count unchanged.
- R4: In single-shot mode (bit 30 = 0) the expiry clears the run bit and leaves the count at 0. Later ticks neither change the count nor expire again.
- R5: In repeat mode (bit 30 = 1) the expiry reloads the count with the stored load value, keeps the run bit set, and fires again every N+1 ticks.
- R6: Writing 0 to offset 0x0 stops the timer, with count 0 and no further expiry.
- R7: A write to offset 0x0 while the timer runs loads the new value into the count at once and restarts the countdown from it. A `tick` in the same cycle as that write is not counted.
- R8: `irq` is active high and rises at the clock edge of the expiry. It stays high until a write to byte offset 0x4 with bit 30 set. A write to 0x4 with bit 30 clear has no effect.
- R9: An expiry while the flag is already pending keeps `irq` high. If a clear and an expiry fall in the same cycle, the expiry wins and `irq` stays high.
- R10: Reading offset 0x4 returns the current count in bits [28:0] and the pending flag in bit 30, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one cycle per count |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (4) | Byte offset of the write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_raddr | input | ADDR_W (4) | Byte offset of the read |
| bus_rdata | output | DATA_W (32) | Read data, combinational from `bus_raddr` |
| irq | output | 1 | Level-high interrupt, the pending flag |

## Verification
The bench sweeps load values 0 to 9 in both modes. It spaces the ticks 0, 1 and 2 idle cycles apart, so an off-by-one in the N+1 rule and counting on idle cycles show up as different errors. Each sweep point checks the count and `irq` one tick before expiry and exactly at expiry. After expiry it checks the run bit and the count, which tell reload apart from stop. Directed patterns cover the cases that set one action against another:
- a rewrite in mid-count;
- a write and a tick in the same cycle;
- a stop;
- a clear written without bit 30;
- a clear that coincides with an expiry.

// File: rtl/etm_pkg.sv
package etm_pkg;
   typedef enum logic [1:0] {
      ETM_SEL_NONE = 2'd0,
      ETM_SEL_TRIG = 2'd1,
      ETM_SEL_STAT = 2'd2
   } etm_sel_e;
endpackage

// File: rtl/etm_addr_dec.sv
module etm_addr_dec
   import etm_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int TRIG_OFS    = 0,
   parameter int STAT_OFS    = 4,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ADDR_W-1:0] raddr,
   output logic              trig_wr,
   output logic              stat_wr,
   output etm_sel_e          rsel
);
   localparam int WORD_LSB = 2;
   localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   logic w_is_trig, w_is_stat, r_is_trig, r_is_stat;

   if (FULL_DECODE) begin : g_full
      assign w_is_trig = (waddr == TRIG_A);
      assign w_is_stat = (waddr == STAT_A);
      assign r_is_trig = (raddr == TRIG_A);
      assign r_is_stat = (raddr == STAT_A);
   end else begin : g_word
      logic unused_low_bits;
      assign unused_low_bits = ^{waddr[WORD_LSB-1:0], raddr[WORD_LSB-1:0]};
      assign w_is_trig = (waddr[ADDR_W-1:WORD_LSB] == TRIG_A[ADDR_W-1:WORD_LSB]);
      assign w_is_stat = (waddr[ADDR_W-1:WORD_LSB] == STAT_A[ADDR_W-1:WORD_LSB]);
      assign r_is_trig = (raddr[ADDR_W-1:WORD_LSB] == TRIG_A[ADDR_W-1:WORD_LSB]);
      assign r_is_stat = (raddr[ADDR_W-1:WORD_LSB] == STAT_A[ADDR_W-1:WORD_LSB]);
   end

   assign trig_wr = wr & w_is_trig;
   assign stat_wr = wr & w_is_stat;

   always_comb begin
      if (r_is_trig)      rsel = ETM_SEL_TRIG;
      else if (r_is_stat) rsel = ETM_SEL_STAT;
      else                rsel = ETM_SEL_NONE;
   end
endmodule

// File: rtl/etm_ctrl_regs.sv
module etm_ctrl_regs #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 29,
   parameter int EN_BIT  = 31,
   parameter int PER_BIT = 30,
   parameter int CLR_BIT = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_wr,
   input  logic              stat_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic              run,
   output logic              periodic,
   output logic [CNT_W-1:0]  load,
   output logic              pending
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   logic clr_req;
   assign clr_req = stat_wr & wdata[CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= 1'b0;
         periodic <= 1'b0;
         load     <= '0;
      end else if (trig_wr) begin
         run      <= wdata[EN_BIT];
         periodic <= wdata[PER_BIT];
         load     <= wdata[CNT_W-1:0];
      end else if (expire && !periodic) begin
         run      <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pending <= 1'b0;
      else if (expire)  pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
   end
endmodule

// File: rtl/etm_down_cnt.sv
module etm_down_cnt #(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_now,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             run,
   input  logic             periodic,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero;
   assign at_zero = (cnt == '0);
   assign expire  = run & tick & ~load_now & at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load_now)      cnt <= load_val;
      else if (run && tick) begin
         if (at_zero)         cnt <= periodic ? reload_val : '0;
         else                 cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/etm_event_timer.sv
module etm_event_timer
   import etm_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int CNT_W       = 29,
   parameter int EN_BIT      = 31,
   parameter int PER_BIT     = 30,
   parameter int CLR_BIT     = 30,
   parameter int PEND_BIT    = 30,
   parameter int TRIG_OFS    = 0,
   parameter int STAT_OFS    = 4,
   parameter bit FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (CNT_W < 1 || CNT_W >= DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..DATA_W-1");
   end
   if (EN_BIT < CNT_W || PER_BIT < CNT_W || EN_BIT == PER_BIT ||
       EN_BIT >= DATA_W || PER_BIT >= DATA_W) begin : g_bad_ctl
      $error("control bits must be distinct and above the load field");
   end
   if (PEND_BIT < CNT_W || PEND_BIT >= DATA_W || CLR_BIT >= DATA_W) begin : g_bad_stat
      $error("status bits out of range");
   end
   if (ADDR_W < 3 || TRIG_OFS == STAT_OFS) begin : g_bad_addr
      $error("address map needs ADDR_W >= 3 and distinct offsets");
   end

   logic             trig_wr, clr_wr, expire;
   logic             cfg_en, cfg_per, pend_q;
   logic [CNT_W-1:0] cfg_load, cnt_q;
   etm_sel_e         rsel;

   etm_addr_dec #(
      .ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS), .STAT_OFS(STAT_OFS),
      .FULL_DECODE(FULL_DECODE)
   ) u_dec (
      .wr(bus_wr), .waddr(bus_addr), .raddr(bus_raddr),
      .trig_wr(trig_wr), .stat_wr(clr_wr), .rsel(rsel)
   );

   etm_ctrl_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
      .PER_BIT(PER_BIT), .CLR_BIT(CLR_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .stat_wr(clr_wr),
      .wdata(bus_wdata), .expire(expire), .run(cfg_en),
      .periodic(cfg_per), .load(cfg_load), .pending(pend_q)
   );

   etm_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_now(trig_wr),
      .load_val(bus_wdata[CNT_W-1:0]), .reload_val(cfg_load),
      .run(cfg_en), .periodic(cfg_per), .tick(tick),
      .cnt(cnt_q), .expire(expire)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (rsel)
         ETM_SEL_TRIG: begin
            bus_rdata[EN_BIT]      = cfg_en;
            bus_rdata[PER_BIT]     = cfg_per;
            bus_rdata[CNT_W-1:0]   = cfg_load;
         end
         ETM_SEL_STAT: begin
            bus_rdata[PEND_BIT]    = pend_q;
            bus_rdata[CNT_W-1:0]   = cnt_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq = pend_q;
endmodule

// File: rtl/etm_event_timer_chk.sv
module etm_event_timer_chk #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 29,
   parameter int CLR_BIT = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              trig_wr,
   input logic              clr_wr,
   input logic [DATA_W-1:0] wdata,
   input logic              run,
   input logic              periodic,
   input logic [CNT_W-1:0]  load,
   input logic [CNT_W-1:0]  cnt,
   input logic              expire,
   input logic              irq
);
   AST_TRIG_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> cnt == $past(wdata[CNT_W-1:0]));                              // R7
   AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !trig_wr && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R3
   AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !trig_wr) |=> $stable(cnt));                                    // R3
   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic) |=> (!run && cnt == '0));                           // R4
   AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && periodic) |=> (run && cnt == $past(load)));                    // R5
   AST_EXPIRY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);                                                          // R9
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(clr_wr && wdata[CLR_BIT])) |=> irq);                            // R8
   AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wdata[CLR_BIT] && !expire) |=> !irq);                          // R8
   AST_STOPPED_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !expire);                                                        // R6
endmodule

bind etm_event_timer etm_event_timer_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .CLR_BIT(CLR_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .trig_wr(trig_wr),
   .clr_wr(clr_wr), .wdata(bus_wdata), .run(cfg_en), .periodic(cfg_per),
   .load(cfg_load), .cnt(cnt_q), .expire(expire), .irq(irq)
);

// File: tb/tb_etm_event_timer.sv
module tb_etm_event_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN  = 32'h8000_0000;
   localparam logic [31:0] PER = 32'h4000_0000;
   localparam logic [31:0] CLR = 32'h4000_0000;
   localparam logic [31:0] PND = 32'h4000_0000;

   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0, bus_raddr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq;
   int          n_tests = 0, n_fail = 0, cycles = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   etm_event_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
         finish_run();
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic tk(int n, int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_raddr = a; #1; d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      rd(4'h0, v); chk("R1 trig", v, 32'h0);
      rd(4'h4, v); chk("R1 stat", v, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // Sweep: mode x load x tick spacing
      for (int per = 0; per < 2; per++) begin
         for (int n = 0; n < 10; n++) begin
            for (int gap = 0; gap < 3; gap++) begin
               logic [31:0] word;
               word = EN | (per != 0 ? PER : 32'h0) | 32'(n);
               wr(4'h0, word);
               rd(4'h0, v); chk("R2 readback", v, word);
               rd(4'h4, v); chk("R10 count after load", v, 32'(n));
               tk(n, gap);
               rd(4'h4, v); chk("R3 before expiry", v, 32'h0);
               chk("R3 irq low before expiry", {31'h0, irq}, 32'h0);
               tk(1, gap);
               chk("R8 irq at expiry", {31'h0, irq}, 32'h1);
               if (per != 0) begin
                  rd(4'h4, v); chk("R5 reload", v, PND | 32'(n));
                  rd(4'h0, v); chk("R5 still running", v, word);
                  tk(n + 1, gap);
                  rd(4'h4, v); chk("R9 second expiry keeps irq", v, PND | 32'(n));
               end else begin
                  rd(4'h0, v); chk("R4 run bit cleared", v, 32'(n));
                  tk(3, gap);
                  rd(4'h4, v); chk("R4 stays stopped", v, PND);
               end
               wr(4'h4, CLR);
               chk("R8 clear", {31'h0, irq}, 32'h0);
               wr(4'h0, 32'h0);
            end
         end
      end

      // R8: clear without bit 30 has no effect
      wr(4'h0, EN | 32'd0); tk(1, 0);
      wr(4'h4, 32'hBFFF_FFFF);
      chk("R8 clear w/o bit30 ignored", {31'h0, irq}, 32'h1);
      wr(4'h4, CLR);
      chk("R8 clear with bit30", {31'h0, irq}, 32'h0);

      // R6: stop by writing zero
      wr(4'h0, EN | 32'd5); tk(2, 1);
      rd(4'h4, v); chk("R6 mid count", v, 32'd3);
      wr(4'h0, 32'h0); tk(10, 0);
      rd(4'h4, v); chk("R6 stopped count", v, 32'h0);
      chk("R6 no irq", {31'h0, irq}, 32'h0);

      // R7: rewrite while running, and tick coinciding with write
      wr(4'h0, EN | 32'd20); tk(5, 0);
      rd(4'h4, v); chk("R7 before rewrite", v, 32'd15);
      wr(4'h0, EN | 32'd3);
      rd(4'h4, v); chk("R7 restart value", v, 32'd3);
      tk(3, 0); chk("R7 not yet", {31'h0, irq}, 32'h0);
      tk(1, 0); chk("R7 expiry", {31'h0, irq}, 32'h1);
      wr(4'h4, CLR);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = EN | 32'd7; tick = 1'b1;
      @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
      rd(4'h4, v); chk("R7 tick with write ignored", v, 32'd7);

      // R9: clear coinciding with expiry loses
      wr(4'h0, EN | PER | 32'd0); tk(1, 0);
      chk("R9 pending", {31'h0, irq}, 32'h1);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = CLR; tick = 1'b1;
      @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
      chk("R9 expiry beats clear", {31'h0, irq}, 32'h1);
      wr(4'h4, CLR);
      chk("R9 later clear", {31'h0, irq}, 32'h0);

      // R10: unmapped offset reads zero, status layout
      rd(4'h8, v); chk("R10 unmapped read", v, 32'h0);
      finish_run();
   end
endmodule